// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical page frame number. It walks a forward-mapped translation table with three levels. A request carries the virtual address and the frame number of the root table. The walker first sorts the address into one of three regions by its two top bits. It rejects addresses whose upper bits are not a sign extension of the meaningful part. It maps the kernel direct region straight through without touching memory. For the two user regions it fetches one 8-byte entry per level over a single request/response memory port, and follows each valid entry to the next table.

Pages are 8 KB and every table fills exactly one page of 1024 entries, so 43 address bits carry translation information: a 13-bit offset and three 10-bit indices. A finished walk raises `done` for one cycle. It then presents the frame number with four permission bits, or a fault code. A missing entry also reports the level at which the walk stopped. Only one walk is in flight at a time, and `busy` holds off new requests until the walk has finished.

Top module: `page_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `memReqValid` are 0.
- R2: At `done`, `resRegion` reports the region from address bits 63 and 62: 0 (user code/heap) when bit 63 is 0, 1 (user stack) when both bits are 1, and 2 (kernel direct) when bit 63 is 1 and bit 62 is 0.
- R3: If address bits 61 down to 42 are not all equal to bit 42, the walk ends with `resFault` = 2 (format), `resPfn` = 0 and `resPerm` = 0. No memory read is issued.
- R4: A canonical kernel-direct address issues no memory read. It ends with `resFault` = 0, `resPfn` = address bits 42..13 zero-extended, and `resPerm` = 4'b0011 (kernel read and kernel write only).
- R5: The read for level L (0, 1, 2) is at byte address {table frame, index L, 3'b000}. Index 0 is address bits 42..33, index 1 is bits 32..23 and index 2 is bits 22..13. The table frame is the root frame at level 0; after that it is bits 63..32 of the entry read at the previous level.
- R6: A walk that succeeds issues exactly three reads, one per level. Each read is a one-cycle `memReqValid` pulse, and the next read waits for the previous response.
- R7: Entry bit 0 is valid, bit 1 kernel read, bit 2 kernel write, bit 3 user read and bit 4 user write; bits 63..32 hold the frame number. A successful walk returns `resFault` = 0, the level-2 entry's frame, and `resPerm` = entry bits 4..1 ({uw, ur, kw, kr}).
- R8: An entry with bit 0 clear at level L ends the walk with `resFault` = 1 (not present), `resLevel` = L, `resPfn` = 0 and `resPerm` = 0. No further read is issued.
- R9: `busy` is 1 from the cycle after a request is accepted until the walk ends. A `reqValid` while busy is ignored: it neither changes the result nor adds reads.
- R10: `done` is a one-cycle pulse. `busy` is 0 in the cycle after it, and all result outputs hold their values until the next request is accepted. `resLevel` is 0 for every outcome except not present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request, accepted when not busy |
| reqVa | input | 64 | Virtual address to translate |
| reqRootPfn | input | 32 | Frame number of the root table |
| busy | output | 1 | A walk is in progress |
| memReqValid | output | 1 | One-cycle read request |
| memReqAddr | output | 45 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data is valid this cycle |
| memRspData | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle pulse when the walk ends |
| resPfn | output | 32 | Translated frame number |
| resPerm | output | 4 | Permissions {uw, ur, kw, kr} |
| resFault | output | 2 | 0 none, 1 not present, 2 bad format |
| resLevel | output | 2 | Level of a not-present fault |
| resRegion | output | 2 | Decoded address region |

## Verification
The hardest case to reach from the ports is a walk that stops partway, at level 1 or 2. The earlier levels must already have returned valid entries that point to real next tables. The bench memory builds every entry from a hash of its address, and clears the valid bit only at a chosen read within the walk. Directed walks use this to fault at each level in turn, and random walks pick the fault level at random. Other walks send requests while the walker is busy, with random response latency, to show that those requests have no effect.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_FORMAT = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    RGN_USER    = 2'd0,
    RGN_STACK   = 2'd1,
    RGN_KDIRECT = 2'd2
  } region_e;

  // control -> datapath
  typedef struct packed {
    logic capture;
    logic issue;
    logic step;
    logic finWalk;
    logic finAbsent;
    logic finFormat;
    logic finKernel;
  } walkStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic canonical;
    logic kernel;
    logic entryValid;
    logic lastLevel;
  } walkStatus_t;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         memRspValid,
  input  walkStatus_t  stat,
  output walkStrobes_t strb,
  output logic         busy,
  output logic         done,
  output logic         memReqValid
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECODE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } state_e;

  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strb.capture = 1'b1;
          stateD       = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (!stat.canonical) begin
          strb.finFormat = 1'b1;
          stateD         = ST_FIN;
        end else if (stat.kernel) begin
          strb.finKernel = 1'b1;
          stateD         = ST_FIN;
        end else begin
          stateD = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        strb.issue = 1'b1;
        stateD     = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (!stat.entryValid) begin
            strb.finAbsent = 1'b1;
            stateD         = ST_FIN;
          end else if (stat.lastLevel) begin
            strb.finWalk = 1'b1;
            stateD       = ST_FIN;
          end else begin
            strb.step = 1'b1;
            stateD    = ST_ISSUE;
          end
        end
      end
      ST_FIN: begin
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy        = (stateQ != ST_IDLE);
  assign done        = (stateQ == ST_FIN);
  assign memReqValid = strb.issue;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  busy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R6
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R10
  one_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.finWalk, strb.finAbsent, strb.finFormat, strb.finKernel}));

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int SIG_W      = 43,
  parameter int PAGE_SHIFT = 13,
  parameter int LEVELS     = 3,
  parameter int PFN_W      = 32,
  parameter int ENTRY_W    = 64,
  parameter int PFN_LSB    = 32,
  localparam int IDX_W     = (SIG_W - PAGE_SHIFT) / LEVELS,
  localparam int ENT_LOG2  = PAGE_SHIFT - IDX_W,
  localparam int PA_W      = PFN_W + PAGE_SHIFT,
  localparam int LVL_W     = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobes_t       strb,
  input  logic [VA_W-1:0]    reqVa,
  input  logic [PFN_W-1:0]   reqRootPfn,
  input  logic [ENTRY_W-1:0] memRspData,
  output walkStatus_t        stat,
  output logic [PA_W-1:0]    memReqAddr,
  output logic [PFN_W-1:0]   resPfn,
  output logic [3:0]         resPerm,
  output logic [1:0]         resFault,
  output logic [LVL_W-1:0]   resLevel,
  output logic [1:0]         resRegion
);

  localparam int KPN_W = SIG_W - PAGE_SHIFT;

  logic [VA_W-1:0]  vaQ;
  logic [PFN_W-1:0] tblQ;
  logic [LVL_W-1:0] levelQ;
  fault_e           faultQ;

  // index field per level, top level first
  logic [IDX_W-1:0] idxOf [LEVELS];
  logic [IDX_W-1:0] curIdx;

  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxOf[g] = vaQ[PAGE_SHIFT + (LEVELS-1-g)*IDX_W +: IDX_W];
  end

  always_comb begin
    curIdx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (levelQ == LVL_W'(i)) curIdx = idxOf[i];
    end
  end

  assign memReqAddr = {tblQ, curIdx, {ENT_LOG2{1'b0}}};

  // entry fields
  logic             rspValidBit;
  logic [3:0]       rspPerm;
  logic [PFN_W-1:0] rspPfn;
  assign rspValidBit = memRspData[0];
  assign rspPerm     = memRspData[4:1];
  assign rspPfn      = memRspData[PFN_LSB +: PFN_W];

  // region and format decode
  logic [VA_W-2-SIG_W:0] upperBits;
  logic                  isCanon;
  region_e               region;
  logic [PFN_W-1:0]      kernPfn;

  assign upperBits = vaQ[VA_W-3:SIG_W-1];
  assign isCanon   = (&upperBits) | ~(|upperBits);
  assign region    = vaQ[VA_W-1] ? (vaQ[VA_W-2] ? RGN_STACK : RGN_KDIRECT)
                                 : RGN_USER;
  assign kernPfn   = {{(PFN_W-KPN_W){1'b0}}, vaQ[SIG_W-1:PAGE_SHIFT]};

  assign stat.canonical  = isCanon;
  assign stat.kernel     = (region == RGN_KDIRECT);
  assign stat.entryValid = rspValidBit;
  assign stat.lastLevel  = (levelQ == LVL_W'(LEVELS-1));

  // walk state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ    <= '0;
      tblQ   <= '0;
      levelQ <= '0;
    end else if (strb.capture) begin
      vaQ    <= reqVa;
      tblQ   <= reqRootPfn;
      levelQ <= '0;
    end else if (strb.step) begin
      tblQ   <= rspPfn;
      levelQ <= levelQ + 1'b1;
    end
  end

  // results
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resPfn   <= '0;
      resPerm  <= '0;
      faultQ   <= FLT_NONE;
      resLevel <= '0;
    end else if (strb.finWalk) begin
      resPfn   <= rspPfn;
      resPerm  <= rspPerm;
      faultQ   <= FLT_NONE;
      resLevel <= '0;
    end else if (strb.finAbsent) begin
      resPfn   <= '0;
      resPerm  <= '0;
      faultQ   <= FLT_ABSENT;
      resLevel <= levelQ;
    end else if (strb.finFormat) begin
      resPfn   <= '0;
      resPerm  <= '0;
      faultQ   <= FLT_FORMAT;
      resLevel <= '0;
    end else if (strb.finKernel) begin
      resPfn   <= kernPfn;
      resPerm  <= 4'b0011;
      faultQ   <= FLT_NONE;
      resLevel <= '0;
    end
  end

  assign resFault  = faultQ;
  assign resRegion = region;

  // R3
  no_read_bad_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.issue |-> (isCanon && region != RGN_KDIRECT));

  // R5
  level_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    levelQ < LVL_W'(LEVELS));

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.finWalk || strb.finAbsent || strb.finFormat || strb.finKernel)
      |=> ($stable(resPfn) && $stable(resPerm) && $stable(faultQ)));

  // R9
  va_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(vaQ));

endmodule

// File: rtl/page_walker.sv
module page_walker
  import ptw_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int SIG_W      = 43,
  parameter int PAGE_SHIFT = 13,
  parameter int LEVELS     = 3,
  parameter int PFN_W      = 32,
  parameter int ENTRY_W    = 64,
  parameter int PFN_LSB    = 32,
  localparam int PA_W      = PFN_W + PAGE_SHIFT,
  localparam int LVL_W     = $clog2(LEVELS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [VA_W-1:0]    reqVa,
  input  logic [PFN_W-1:0]   reqRootPfn,
  output logic               busy,
  output logic               memReqValid,
  output logic [PA_W-1:0]    memReqAddr,
  input  logic               memRspValid,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic               done,
  output logic [PFN_W-1:0]   resPfn,
  output logic [3:0]         resPerm,
  output logic [1:0]         resFault,
  output logic [LVL_W-1:0]   resLevel,
  output logic [1:0]         resRegion
);

  walkStrobes_t strb;
  walkStatus_t  stat;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRspValid (memRspValid),
    .stat        (stat),
    .strb        (strb),
    .busy        (busy),
    .done        (done),
    .memReqValid (memReqValid)
  );

  ptw_datapath #(
    .VA_W       (VA_W),
    .SIG_W      (SIG_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .LEVELS     (LEVELS),
    .PFN_W      (PFN_W),
    .ENTRY_W    (ENTRY_W),
    .PFN_LSB    (PFN_LSB)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqVa      (reqVa),
    .reqRootPfn (reqRootPfn),
    .memRspData (memRspData),
    .stat       (stat),
    .memReqAddr (memReqAddr),
    .resPfn     (resPfn),
    .resPerm    (resPerm),
    .resFault   (resFault),
    .resLevel   (resLevel),
    .resRegion  (resRegion)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !$past(rstN) |-> (!busy && !done && !memReqValid));

endmodule

// File: tb/sim_page_walker.sv
module sim_page_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] reqVa = '0;
  logic [31:0] reqRootPfn = '0;
  logic        busy, memReqValid, done;
  logic [44:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic [31:0] resPfn;
  logic [3:0]  resPerm;
  logic [1:0]  resFault, resLevel, resRegion;

  always #10 clk = ~clk;  // 50 MHz

  page_walker u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVa(reqVa),
    .reqRootPfn(reqRootPfn), .busy(busy), .memReqValid(memReqValid),
    .memReqAddr(memReqAddr), .memRspValid(memRspValid),
    .memRspData(memRspData), .done(done), .resPfn(resPfn),
    .resPerm(resPerm), .resFault(resFault), .resLevel(resLevel),
    .resRegion(resRegion)
  );

  int nChecks = 0;
  int nFails  = 0;

  // memory model state
  int          rdCount = 0;
  int          forceInvalid = 9;
  logic [44:0] recAddr [4];
  logic [44:0] pendAddr = '0;
  int          pendCnt = 0;

  function automatic logic [63:0] mix(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x >> 29);
    y = y * 64'hBF58476D1CE4E5B9;
    y = y ^ (y >> 32);
    return y;
  endfunction

  // bit0 valid, bits4..1 perms, bits63..32 frame
  function automatic logic [63:0] memEntry(input logic [44:0] a, input int lvl,
                                           input int inv);
    logic [63:0] h;
    h = mix({19'b0, a});
    return {h[63:32], 27'b0, h[3:0], (lvl == inv) ? 1'b0 : 1'b1};
  endfunction

  always @(negedge clk) begin
    memRspValid = 1'b0;
    if (pendCnt > 0) begin
      pendCnt--;
      if (pendCnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = memEntry(pendAddr, rdCount - 1, forceInvalid);
      end
    end
    if (memReqValid) begin
      if (rdCount < 4) recAddr[rdCount] = memReqAddr;
      rdCount++;
      pendAddr = memReqAddr;
      pendCnt  = $urandom_range(1, 3);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFails++;
      nChecks++;
      $display("FAIL R10 watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic runWalk(input logic [63:0] va, input logic [31:0] root,
                         input int inv, input bit inject);
    logic [1:0]  eRegion, eFault, eLevel;
    logic [31:0] ePfn, tbl;
    logic [3:0]  ePerm;
    logic [44:0] eAddr [3];
    logic [63:0] d;
    logic [19:0] up;
    int          eReads;
    string       rq;
    eRegion = va[63] ? (va[62] ? 2'd1 : 2'd2) : 2'd0;
    up = va[61:42];
    eFault = 0; eLevel = 0; ePfn = 0; ePerm = 0; eReads = 0; tbl = root;
    if (!((&up) | ~(|up))) begin
      eFault = 2;
    end else if (eRegion == 2) begin
      ePfn = {2'b0, va[42:13]}; ePerm = 4'b0011;
    end else begin
      for (int l = 0; l < 3; l++) begin
        eAddr[l] = {tbl, va[42-10*l -: 10], 3'b000};
        eReads++;
        d = memEntry(eAddr[l], l, inv);
        if (!d[0]) begin
          eFault = 1; eLevel = 2'(l);
          break;
        end
        if (l == 2) begin
          ePfn = d[63:32]; ePerm = d[4:1];
        end else tbl = d[63:32];
      end
    end
    forceInvalid = inv;
    rdCount = 0;
    @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqRootPfn = root;
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == 1'b1, "R9", "busy after accept", busy, 1);
    while (!done) begin
      reqValid = inject;
      reqVa = {2'b10, 62'h155} ^ {32'h0, $urandom};
      reqRootPfn = $urandom;
      @(negedge clk);
    end
    reqValid = 1'b0;
    rq = (eFault == 2) ? "R3" : (eRegion == 2) ? "R4" :
         (eFault == 1) ? "R8" : "R7";
    check(resRegion == eRegion, "R2", "region", resRegion, eRegion);
    check(resFault == eFault, rq, "fault", resFault, eFault);
    check(resPfn == ePfn, rq, "pfn", resPfn, ePfn);
    check(resPerm == ePerm, rq, "perm", resPerm, ePerm);
    check(resLevel == eLevel, "R8", "level", resLevel, eLevel);
    check(rdCount == eReads, (eReads == 3) ? "R6" : rq, "read count",
          rdCount, eReads);
    for (int l = 0; l < eReads && l < rdCount; l++)
      check(recAddr[l] == eAddr[l], "R5", "read address", recAddr[l], eAddr[l]);
    @(negedge clk);
    check(!done && !busy, "R10", "done pulse/busy release", {done, busy}, 0);
    check(resPfn == ePfn && resFault == eFault, "R10", "result held",
          resPfn, ePfn);
  endtask

  function automatic logic [63:0] mkVa(input logic [1:0] top, input logic [42:0] low);
    return {top, {19{low[42]}}, low};
  endfunction

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !memReqValid, "R1", "during reset",
          {busy, done, memReqValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !memReqValid, "R1", "after reset",
          {busy, done, memReqValid}, 0);

    // directed
    runWalk(mkVa(2'b00, 43'h123_4567_89AB), 32'h0000_1000, 9, 0); // R7 user
    runWalk(mkVa(2'b11, 43'h7FF_FFFF_E000), 32'hABCD_0001, 9, 0); // R2 stack
    runWalk(mkVa(2'b10, 43'h555_5555_5555), 32'h0, 9, 0);         // R4
    runWalk(mkVa(2'b10, 43'h7FF_FFFF_FFFF), 32'h0, 9, 0);         // R4 top
    runWalk(mkVa(2'b00, 43'h1) ^ (64'h1 << 61), 32'h5, 9, 0);     // R3
    runWalk(mkVa(2'b11, 43'h400_0000_0000) ^ (64'h1 << 43), 32'h5, 9, 0); // R3
    runWalk(mkVa(2'b10, 43'h0) ^ (64'h1 << 50), 32'h5, 9, 0);     // R3 kernel
    runWalk(mkVa(2'b00, 43'h0ABC_DEF0_1234), 32'h77, 0, 0);       // R8 lvl0
    runWalk(mkVa(2'b00, 43'h0ABC_DEF0_1234), 32'h77, 1, 0);       // R8 lvl1
    runWalk(mkVa(2'b11, 43'h7AB_CDEF_0123), 32'h78, 2, 0);        // R8 lvl2
    runWalk(mkVa(2'b00, 43'h222_3333_4444), 32'h99, 9, 1);        // R9 inject
    runWalk(mkVa(2'b00, 43'h222_3333_4444), 32'h99, 1, 1);        // R9 inject

    // random
    for (int n = 0; n < 80; n++) begin
      logic [63:0] va;
      int inv;
      va = mkVa(2'($urandom_range(0, 3)), {11'($urandom), $urandom});
      if ($urandom_range(0, 7) == 0)
        va = va ^ (64'h1 << $urandom_range(43, 61));
      inv = $urandom_range(0, 5);
      runWalk(va, $urandom, inv, 1'($urandom_range(0, 1)));
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule